// File: doc/BRIEF.md
# Cartridge Bank Register Decoder

This block sits between the console CPU bus and a game cartridge's memories. Writes from the CPU land in a small register file. Only the low four address bits pick the register, so the set repeats every 16 bytes across an accepted window. The stored values then turn CPU and PPU addresses into banked ROM addresses. A 16 KiB program slot at $8000-$BFFF is switchable. The slot at $C000-$FFFF is pinned to the highest bank. Eight independently switchable 1 KiB pattern banks cover PPU $0000-$1FFF, and a 2-bit mode chooses how the nametable select line follows the PPU address.

Reads anywhere in $6000-$7FFF return a status byte. It carries the save-memory serial data on bit 4 and an auxiliary serial input on bit 3. The other bits repeat the last value the CPU wrote, which stands in for an undriven bus.

Offsets $A to $D are not stored here. Each one raises its own one-hot write strobe for the neighbouring timer and serial-memory blocks, which take the data from the CPU bus themselves. Offsets $E and $F do nothing.

Top module: `cart_bank_decoder`

## Requirements
- R1: After reset, all eight pattern bank registers and the program bank register read 0, the mirroring mode is vertical, and the bus latch holds 0.
- R2: Register selection uses cpu_addr[3:0] only. A write to any address in the accepted window with the same low nibble updates the same register.
- R3: With LOW_WINDOW=1, writes are accepted anywhere in $6000-$FFFF. With LOW_WINDOW=0, they are accepted only in $8000-$FFFF. Writes below the accepted window change no register.
- R4: Offsets 0..7 hold the pattern bank numbers for PPU windows $0000, $0400, ... $1C00, in that order. chr_bank shows the register chosen by ppu_addr[12:10].
- R5: Offset 8 stores cpu_wdata[3:0] as the program bank. Upper data bits are dropped. For cpu_addr in $8000-$BFFF, prg_bank equals that stored value.
- R6: For cpu_addr in $C000-$FFFF, prg_bank is all ones (the last bank), whatever offset 8 holds.
- R7: Offset 9 bits [1:0] set the mirroring mode. In mode 0, nt_sel equals ppu_addr[10]. In mode 1, it equals ppu_addr[11]. Mode 2 drives 0 and mode 3 drives 1.
- R8: While cpu_rd is high and cpu_addr is in $6000-$7FFF, rd_hit is 1. rd_data bit 4 is ser_data_in, bit 3 is aux_data_in, and bits 7:5 and 2:0 come from the last byte written on the CPU bus at any address. Outside that range, rd_hit is 0.
- R9: An accepted write at offset $A, $B, $C or $D raises ext_wr bit 0, 1, 2 or 3 respectively, in the same cycle as the write. At most one bit is ever high, and none is high without a write. Offsets $E and $F change no register.
- R10: A register write takes effect at the rising clock edge during which cpu_wr is high. Before that edge, the outputs still show the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU data bus during writes |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_rd | input | 1 | Read strobe |
| ppu_addr | input | 14 | PPU address |
| ser_data_in | input | 1 | Serial save-memory data |
| aux_data_in | input | 1 | Auxiliary serial input |
| prg_bank | output | 4 | Program ROM 16 KiB bank number |
| chr_bank | output | 8 | Pattern ROM 1 KiB bank number |
| nt_sel | output | 1 | Nametable select line |
| rd_data | output | 8 | Status byte for $6000-$7FFF reads |
| rd_hit | output | 1 | Status read is active |
| ext_wr | output | 4 | One-hot strobes for offsets $A-$D |

## Verification
If a bank register picks up the wrong value, it shows on prg_bank or chr_bank in the first cycle after the write, as soon as the matching CPU or PPU address is presented. A mirroring fault shows on nt_sel on the next PPU access that toggles A10 or A11. A stale or corrupted bus latch appears only in the outer bits of the next status read. Decode faults in the window or the offset show either as a register changing after a write that should have been ignored, or as a wrong or doubled ext_wr bit in the very cycle of the write.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

    typedef enum logic [1:0] {
        MIR_VERT  = 2'd0,
        MIR_HORZ  = 2'd1,
        MIR_LOW   = 2'd2,
        MIR_HIGH  = 2'd3
    } mirror_e;

    localparam int unsigned NUM_CHR     = 8;
    localparam int unsigned OFS_PRG     = 8;
    localparam int unsigned OFS_MIR     = 9;
    localparam int unsigned OFS_EXT0    = 10;
    localparam int unsigned NUM_EXT     = 4;

endpackage

// File: rtl/cbd_window.sv
module cbd_window #(
    parameter bit LOW_WINDOW = 1'b1,
    parameter int unsigned NUM_EXT = 4,
    parameter int unsigned EXT_BASE = 10
) (
    input  logic [15:0]        cpu_addr,
    input  logic               cpu_wr,
    input  logic               cpu_rd,
    output logic               wr_en,
    output logic [3:0]         wr_ofs,
    output logic [NUM_EXT-1:0] ext_wr,
    output logic               rd_hit
);
    logic in_win;

    generate
        if (LOW_WINDOW) begin : g_low
            assign in_win = (cpu_addr[15] == 1'b1) || (cpu_addr[15:13] == 3'b011);
        end else begin : g_high
            assign in_win = cpu_addr[15];
        end
    endgenerate

    assign wr_en  = cpu_wr && in_win;
    assign wr_ofs = cpu_addr[3:0];
    assign rd_hit = cpu_rd && (cpu_addr[15:13] == 3'b011);

    generate
        for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
            assign ext_wr[i] = wr_en && (wr_ofs == 4'(EXT_BASE + i));
        end
    endgenerate
endmodule

// File: rtl/cbd_regs.sv
module cbd_regs #(
    parameter int unsigned CHR_W = 8,
    parameter int unsigned PRG_W = 4,
    parameter int unsigned NUM_CHR = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [3:0]                    wr_ofs,
    input  logic                          cpu_wr,
    input  logic [7:0]                    cpu_wdata,
    output logic [NUM_CHR-1:0][CHR_W-1:0] chr_q,
    output logic [PRG_W-1:0]              prg_q,
    output logic [1:0]                    mir_q,
    output logic [7:0]                    bus_q
);
    import cart_bank_pkg::*;

    typedef struct packed {
        logic [NUM_CHR-1:0][CHR_W-1:0] chr;
        logic [PRG_W-1:0]              prg;
        logic [1:0]                    mir;
        logic [7:0]                    bus;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cpu_wr) begin
            st_d.bus = cpu_wdata;
        end
        if (wr_en) begin
            if (int'(wr_ofs) < NUM_CHR) begin
                st_d.chr[wr_ofs[2:0]] = cpu_wdata[CHR_W-1:0];
            end else if (int'(wr_ofs) == OFS_PRG) begin
                st_d.prg = cpu_wdata[PRG_W-1:0];
            end else if (int'(wr_ofs) == OFS_MIR) begin
                st_d.mir = cpu_wdata[1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.mir <= MIR_VERT;
        end else begin
            st_q <= st_d;
        end
    end

    assign chr_q = st_q.chr;
    assign prg_q = st_q.prg;
    assign mir_q = st_q.mir;
    assign bus_q = st_q.bus;
endmodule

// File: rtl/cbd_ppu_map.sv
module cbd_ppu_map #(
    parameter int unsigned CHR_W = 8,
    parameter int unsigned NUM_CHR = 8
) (
    input  logic [13:0]                   ppu_addr,
    input  logic [NUM_CHR-1:0][CHR_W-1:0] chr_q,
    input  logic [1:0]                    mir_q,
    output logic [CHR_W-1:0]              chr_bank,
    output logic                          nt_sel
);
    import cart_bank_pkg::*;

    localparam int unsigned SEL_W = $clog2(NUM_CHR);

    assign chr_bank = chr_q[ppu_addr[10 +: SEL_W]];

    always_comb begin
        case (mirror_e'(mir_q))
            MIR_VERT: nt_sel = ppu_addr[10];
            MIR_HORZ: nt_sel = ppu_addr[11];
            MIR_LOW:  nt_sel = 1'b0;
            default:  nt_sel = 1'b1;
        endcase
    end
endmodule

// File: rtl/cbd_cpu_map.sv
module cbd_cpu_map #(
    parameter int unsigned PRG_W = 4
) (
    input  logic [15:0]      cpu_addr,
    input  logic [PRG_W-1:0] prg_q,
    input  logic [7:0]       bus_q,
    input  logic             ser_data_in,
    input  logic             aux_data_in,
    output logic [PRG_W-1:0] prg_bank,
    output logic [7:0]       rd_data
);
    assign prg_bank = cpu_addr[14] ? {PRG_W{1'b1}} : prg_q;
    assign rd_data  = {bus_q[7:5], ser_data_in, aux_data_in, bus_q[2:0]};
endmodule

// File: rtl/cart_bank_decoder.sv
module cart_bank_decoder #(
    parameter bit          LOW_WINDOW = 1'b1,
    parameter int unsigned CHR_W = 8,
    parameter int unsigned PRG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [15:0]      cpu_addr,
    input  logic [7:0]       cpu_wdata,
    input  logic             cpu_wr,
    input  logic             cpu_rd,
    input  logic [13:0]      ppu_addr,
    input  logic             ser_data_in,
    input  logic             aux_data_in,
    output logic [PRG_W-1:0] prg_bank,
    output logic [CHR_W-1:0] chr_bank,
    output logic             nt_sel,
    output logic [7:0]       rd_data,
    output logic             rd_hit,
    output logic [3:0]       ext_wr
);
    import cart_bank_pkg::*;

    logic                          wr_en;
    logic [3:0]                    wr_ofs;
    logic [NUM_CHR-1:0][CHR_W-1:0] chr_q;
    logic [PRG_W-1:0]              prg_q;
    logic [1:0]                    mir_q;
    logic [7:0]                    bus_q;

    cbd_window #(.LOW_WINDOW(LOW_WINDOW), .NUM_EXT(NUM_EXT), .EXT_BASE(OFS_EXT0)) u_win (
        .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .wr_en(wr_en), .wr_ofs(wr_ofs), .ext_wr(ext_wr), .rd_hit(rd_hit)
    );

    cbd_regs #(.CHR_W(CHR_W), .PRG_W(PRG_W), .NUM_CHR(NUM_CHR)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ofs(wr_ofs),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .chr_q(chr_q), .prg_q(prg_q), .mir_q(mir_q), .bus_q(bus_q)
    );

    cbd_ppu_map #(.CHR_W(CHR_W), .NUM_CHR(NUM_CHR)) u_ppu (
        .ppu_addr(ppu_addr), .chr_q(chr_q), .mir_q(mir_q),
        .chr_bank(chr_bank), .nt_sel(nt_sel)
    );

    cbd_cpu_map #(.PRG_W(PRG_W)) u_cpu (
        .cpu_addr(cpu_addr), .prg_q(prg_q), .bus_q(bus_q),
        .ser_data_in(ser_data_in), .aux_data_in(aux_data_in),
        .prg_bank(prg_bank), .rd_data(rd_data)
    );
endmodule

// File: rtl/cart_bank_decoder_chk.sv
module cart_bank_decoder_chk #(
    parameter bit          LOW_WINDOW = 1'b1,
    parameter int unsigned PRG_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [15:0]      cpu_addr,
    input logic [7:0]       cpu_wdata,
    input logic             cpu_wr,
    input logic [13:0]      ppu_addr,
    input logic             ser_data_in,
    input logic             aux_data_in,
    input logic [PRG_W-1:0] prg_bank,
    input logic             nt_sel,
    input logic [7:0]       rd_data,
    input logic             rd_hit,
    input logic [3:0]       ext_wr,
    input logic [PRG_W-1:0] prg_q,
    input logic [1:0]       mir_q
);
    logic below_win;
    assign below_win = LOW_WINDOW ? (cpu_addr < 16'h6000) : (cpu_addr < 16'h8000);

    a_r9_onehot_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ext_wr));

    a_r9_strobe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_wr != 4'd0) |-> cpu_wr);

    a_r6_last_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b11) |-> (prg_bank == {PRG_W{1'b1}}));

    a_r5_prg_store: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15] && cpu_addr[3:0] == 4'h8) |=> (prg_q == $past(cpu_wdata[PRG_W-1:0])));

    a_r3_ignore_below: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_wr || below_win) |=> ($stable(prg_q) && $stable(mir_q)));

    a_r8_serial_bits: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> (rd_data[4] == ser_data_in && rd_data[3] == aux_data_in));

    a_r7_tied_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mir_q == 2'd3) |-> nt_sel);

    a_r7_horz_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (mir_q == 2'd1) |-> (nt_sel == ppu_addr[11]));
endmodule

bind cart_bank_decoder cart_bank_decoder_chk #(.LOW_WINDOW(LOW_WINDOW), .PRG_W(PRG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr),
    .ppu_addr(ppu_addr), .ser_data_in(ser_data_in), .aux_data_in(aux_data_in),
    .prg_bank(prg_bank), .nt_sel(nt_sel), .rd_data(rd_data), .rd_hit(rd_hit),
    .ext_wr(ext_wr), .prg_q(prg_q), .mir_q(mir_q)
);

// File: tb/sim_cart_bank_decoder.sv
module sim_cart_bank_decoder;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [13:0] ppu_addr = 14'h0000;
    logic        ser_data_in = 1'b0;
    logic        aux_data_in = 1'b0;
    logic [3:0]  prg_bank, prg_bank1;
    logic [7:0]  chr_bank, chr_bank1;
    logic        nt_sel, nt_sel1;
    logic [7:0]  rd_data, rd_data1;
    logic        rd_hit, rd_hit1;
    logic [3:0]  ext_wr, ext_wr1;

    int n_tests = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cart_bank_decoder #(.LOW_WINDOW(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .ppu_addr(ppu_addr),
        .ser_data_in(ser_data_in), .aux_data_in(aux_data_in),
        .prg_bank(prg_bank), .chr_bank(chr_bank), .nt_sel(nt_sel),
        .rd_data(rd_data), .rd_hit(rd_hit), .ext_wr(ext_wr)
    );

    cart_bank_decoder #(.LOW_WINDOW(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .ppu_addr(ppu_addr),
        .ser_data_in(ser_data_in), .aux_data_in(aux_data_in),
        .prg_bank(prg_bank1), .chr_bank(chr_bank1), .nt_sel(nt_sel1),
        .rd_data(rd_data1), .rd_hit(rd_hit1), .ext_wr(ext_wr1)
    );

    task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_addr = 16'h0000;
    endtask

    task automatic prg_at(input logic [15:0] a, output logic [3:0] b0, output logic [3:0] b1);
        @(negedge clk);
        cpu_addr = a;
        #1;
        b0 = prg_bank; b1 = prg_bank1;
    endtask

    task automatic chr_at(input logic [13:0] p, output logic [7:0] b);
        @(negedge clk);
        ppu_addr = p;
        #1;
        b = chr_bank;
    endtask

    task automatic t_reset;
        logic [3:0] a, b;
        logic [7:0] c;
        for (int i = 0; i < 8; i++) begin
            chr_at(14'(i * 16'h0400), c);
            check("R1", "chr after reset", 16'(c), 16'h0000);
        end
        prg_at(16'h8000, a, b);
        check("R1", "prg after reset", 16'(a), 16'h0000);
        ppu_addr = 14'h0400; #1;
        check("R1", "vertical after reset A10=1", 16'(nt_sel), 16'h0001);
        ppu_addr = 14'h0800; #1;
        check("R1", "vertical after reset A11=1", 16'(nt_sel), 16'h0000);
    endtask

    task automatic t_chr_banks;
        logic [7:0] c;
        for (int i = 0; i < 8; i++) cpu_write(16'h8000 + 16'(i), 8'h30 + 8'(i * 3));
        for (int i = 0; i < 8; i++) begin
            chr_at(14'(i * 16'h0400 + 16'h0123), c);
            check("R4", "chr window", 16'(c), 16'(8'h30 + 8'(i * 3)));
        end
    endtask

    task automatic t_prg_and_mirror_offsets;
        logic [3:0] a, b;
        cpu_write(16'h9FF8, 8'h05);
        prg_at(16'hA000, a, b);
        check("R2", "prg via $9FF8", 16'(a), 16'h0005);
        cpu_write(16'h8008, 8'hF3);
        prg_at(16'hBFFF, a, b);
        check("R5", "prg keeps low nibble", 16'(a), 16'h0003);
        prg_at(16'hC000, a, b);
        check("R6", "prg at $C000", 16'(a), 16'h000F);
        prg_at(16'hFFFF, a, b);
        check("R6", "prg at $FFFF", 16'(a), 16'h000F);
        cpu_write(16'hE4C5, 8'hAA);
        chr_at(14'h1400, a[0] == 1'b0 ? chr_bank : chr_bank);
        check("R2", "chr5 via $E4C5", 16'(chr_bank), 16'h00AA);
    endtask

    task automatic t_mirroring;
        cpu_write(16'h8009, 8'h01);
        ppu_addr = 14'h0800; #1;
        check("R7", "horz A11=1", 16'(nt_sel), 16'h0001);
        ppu_addr = 14'h0400; #1;
        check("R7", "horz A10=1", 16'(nt_sel), 16'h0000);
        cpu_write(16'h8009, 8'hFE);
        ppu_addr = 14'h0C00; #1;
        check("R7", "single low", 16'(nt_sel), 16'h0000);
        cpu_write(16'h8009, 8'h03);
        ppu_addr = 14'h0000; #1;
        check("R7", "single high", 16'(nt_sel), 16'h0001);
        cpu_write(16'h8019, 8'h00);
        ppu_addr = 14'h0400; #1;
        check("R7", "vertical A10=1", 16'(nt_sel), 16'h0001);
    endtask

    task automatic t_window;
        logic [3:0] a, b;
        cpu_write(16'h8008, 8'h02);
        cpu_write(16'h6008, 8'h07);
        prg_at(16'h8000, a, b);
        check("R3", "low window accepts $6008", 16'(a), 16'h0007);
        check("R3", "high-only window ignores $6008", 16'(b), 16'h0002);
        cpu_write(16'h5FF8, 8'h09);
        prg_at(16'h8000, a, b);
        check("R3", "below window ignored", 16'(a), 16'h0007);
    endtask

    task automatic t_read_port;
        cpu_write(16'h4000, 8'hA5);
        @(negedge clk);
        cpu_addr = 16'h7F00; cpu_rd = 1'b1; ser_data_in = 1'b1; aux_data_in = 1'b0;
        #1;
        check("R8", "rd_hit in window", 16'(rd_hit), 16'h0001);
        check("R8", "status byte", 16'(rd_data), 16'h00B5);
        ser_data_in = 1'b0; aux_data_in = 1'b1;
        #1;
        check("R8", "status byte aux", 16'(rd_data), 16'h00AD);
        cpu_addr = 16'h8000;
        #1;
        check("R8", "rd_hit outside", 16'(rd_hit), 16'h0000);
        cpu_rd = 1'b0;
    endtask

    task automatic t_strobes;
        logic [3:0] a, b;
        logic [7:0] c;
        @(negedge clk);
        cpu_addr = 16'h800A; cpu_wdata = 8'h01; cpu_wr = 1'b1; #1;
        check("R9", "strobe $A", 16'(ext_wr), 16'h0001);
        cpu_addr = 16'hC01D; #1;
        check("R9", "strobe $D", 16'(ext_wr), 16'h0008);
        cpu_addr = 16'h800E; #1;
        check("R9", "no strobe $E", 16'(ext_wr), 16'h0000);
        cpu_addr = 16'h4000; #1;
        check("R9", "no strobe outside", 16'(ext_wr), 16'h0000);
        @(negedge clk);
        cpu_wr = 1'b0;
        cpu_write(16'h800E, 8'h0C);
        cpu_write(16'h800F, 8'h01);
        prg_at(16'h8000, a, b);
        check("R9", "offsets E/F leave prg", 16'(a), 16'h0007);
        chr_at(14'h0000, c);
        check("R9", "offsets E/F leave chr0", 16'(c), 16'h0030);
    endtask

    task automatic t_timing;
        @(negedge clk);
        cpu_addr = 16'h8008; cpu_wdata = 8'h0B; cpu_wr = 1'b1; #1;
        check("R10", "old prg before edge", 16'(prg_bank), 16'h0007);
        @(negedge clk);
        cpu_wr = 1'b0; #1;
        check("R10", "new prg after edge", 16'(prg_bank), 16'h000B);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_chr_banks();
        t_prg_and_mirror_offsets();
        t_mirroring();
        t_window();
        t_read_port();
        t_strobes();
        t_timing();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule